// File: doc/BRIEF.md
# Multi-Sequence Line Pulse Generator

This block makes one timing pulse per image line, such as a clamp window or a pre-blank window, for an image-sensor timing front end. A line/frame sequencer outside the block supplies a 12-bit pixel count and a 12-bit line count. The block holds four programmable waveforms, called sequences. Each sequence has a start level and two toggle pixels. At pixel 0 of a line the pulse takes the start level of the active sequence. It then inverts at each toggle pixel.

A small table of sequence-change lines chooses the sequence for each line. Each entry has a start line and a 2-bit pointer to a sequence. The active sequence is fixed once per line, at pixel 0. A source bit selects what drives the output: the internal waveform, or an external pulse input. The external input passes through a two-flop synchronizer and has a programmable active level. Configuration is written through a simple 6-bit-wide parallel write port. The serial interface that drives that port is outside the block.

Top module: `line_pulse_gen`

## Requirements
- R1: A write (`wr_en`=1) stores `wr_data` into the addressed field, and the new value takes effect from the next clock. The address map is as follows.
  - Address 0: bit 0 is the source (1 = external, 0 = internal) and bit 1 is the external active level (1 = high active).
  - Address 1: bits [3:0] are the start levels of sequences 0..3, with bit n belonging to sequence n.
  - Address 2: bits [1:0], [3:2] and [5:4] are the pointers of change entries 0, 1 and 2.
  - Address 3: bits [1:0] are the pointer of change entry 3.
  - Address 8+4n+k sets a toggle half of sequence n. k=0 is toggle 1 bits [5:0], k=1 is toggle 1 bits [11:6], k=2 is toggle 2 bits [5:0] and k=3 is toggle 2 bits [11:6].
  - Address 24+2(c-1)+h sets change line c (c=1..3). h=0 is bits [5:0] and h=1 is bits [11:6].
- R2: The reset defaults are as follows.
  - Source is external, active low.
  - Start levels are 1,1,0,1 for sequences 0..3.
  - Sequence 0 toggles at 0x00E and 0x02B. Sequence 1 toggles at 0x1AB and 0xFFF. Sequences 2 and 3 toggle at 0xFFF for both toggles.
  - Change lines are 0 (fixed), 1, 2 and 0x0F7, with pointers 3, 1, 0 and 3.
  - `pulse_out` is 0 while `rst_n` is low.
- R3: In internal mode, a cycle presenting pixel 0 sets the pulse to the start level of the sequence selected for that line.
- R4: In internal mode the pulse inverts in a cycle whose pixel equals toggle 1, and inverts in a cycle whose pixel equals toggle 2. When both toggles equal the pixel, the two inversions cancel. In any other cycle the pulse holds its level.
- R5: A toggle value of 0xFFF (all ones) never inverts the pulse, even when the pixel count is 0xFFF.
- R6: The selected change entry is the one with the highest line number not above the current line. Change line 0 is fixed at 0. When entries have equal line numbers, the higher-numbered entry wins. The sequence used is that entry's pointer.
- R7: The active sequence is captured only in cycles presenting pixel 0. A change of line count during a line does not change the sequence until the next pixel 0.
- R8: In external mode `pulse_out` equals `ext_in` (active high) or its inverse (active low), delayed by three clock edges.
- R9: `pulse_out` is a register output. The value for the pixel presented before a clock edge appears after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_cnt | input | 12 | Pixel index within the line |
| line_cnt | input | 12 | Line index within the frame |
| ext_in | input | 1 | External pulse input, asynchronous |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 5 | Configuration word address |
| wr_data | input | 6 | Configuration write data |
| pulse_out | output | 1 | Generated line pulse |

## Verification
The waveform is first tried with the default configuration on lines that fall under each change entry. Pixels are placed just before, on and just after each toggle, so the test shows which sequence was picked and whether each toggle fired. Further steps check the following:
- A toggle at 0xFFF probed at pixel 0xFFF shows that the disable rule overrides a real match.
- A line count changed in the middle of a line shows whether the sequence is latched at pixel 0.
- Equal toggles, and equal change lines, check the cancel rule and the tie rule.
- External mode is stepped edge by edge to tell a three-edge delay from a shorter one, in both polarities.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    localparam int NSEQ   = 4;
    localparam int NCHG   = 4;
    localparam int CNT_W  = 12;
    localparam int HALF_W = CNT_W / 2;
    localparam int SEL_W  = $clog2(NSEQ);
    localparam int CIDX_W = $clog2(NCHG);
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADDR_CTRL     = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_START    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_PTR_LO   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADDR_PTR_HI   = ADDR_W'(3);
    localparam int                ADDR_TOG_BASE = 8;
    localparam int                ADDR_CHG_BASE = 24;

    localparam logic [CNT_W-1:0] TOG_OFF = {CNT_W{1'b1}};

    typedef struct packed {
        logic                             src_ext;
        logic                             ext_high;
        logic [NSEQ-1:0]                  start;
        logic [NCHG-1:0][SEL_W-1:0]       ptr;
        logic [NSEQ-1:0][CNT_W-1:0]       tog1;
        logic [NSEQ-1:0][CNT_W-1:0]       tog2;
        logic [NCHG-1:0][CNT_W-1:0]       chg;
    } lpg_cfg_t;

    function automatic lpg_cfg_t lpg_reset_cfg();
        lpg_cfg_t c;
        c.src_ext  = 1'b1;
        c.ext_high = 1'b0;
        c.start    = 4'b1011;
        c.ptr[0]   = 2'd3;
        c.ptr[1]   = 2'd1;
        c.ptr[2]   = 2'd0;
        c.ptr[3]   = 2'd3;
        c.tog1[0]  = 12'h00E;
        c.tog2[0]  = 12'h02B;
        c.tog1[1]  = 12'h1AB;
        c.tog2[1]  = TOG_OFF;
        c.tog1[2]  = TOG_OFF;
        c.tog2[2]  = TOG_OFF;
        c.tog1[3]  = TOG_OFF;
        c.tog2[3]  = TOG_OFF;
        c.chg[0]   = '0;
        c.chg[1]   = 12'h001;
        c.chg[2]   = 12'h002;
        c.chg[3]   = 12'h0F7;
        return c;
    endfunction

endpackage

// File: rtl/lpg_regs.sv
module lpg_regs
    import lpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output lpg_cfg_t          cfg
);

    lpg_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                cfg_d.src_ext  = wr_data[0];
                cfg_d.ext_high = wr_data[1];
            end
            if (wr_addr == ADDR_START) begin
                cfg_d.start = wr_data[NSEQ-1:0];
            end
            if (wr_addr == ADDR_PTR_LO) begin
                for (int c = 0; c < 3; c++) begin
                    cfg_d.ptr[c] = wr_data[c*SEL_W +: SEL_W];
                end
            end
            if (wr_addr == ADDR_PTR_HI) begin
                cfg_d.ptr[3] = wr_data[SEL_W-1:0];
            end
            for (int s = 0; s < NSEQ; s++) begin
                if (wr_addr == ADDR_W'(ADDR_TOG_BASE + 4*s + 0)) cfg_d.tog1[s][HALF_W-1:0]     = wr_data;
                if (wr_addr == ADDR_W'(ADDR_TOG_BASE + 4*s + 1)) cfg_d.tog1[s][CNT_W-1:HALF_W] = wr_data;
                if (wr_addr == ADDR_W'(ADDR_TOG_BASE + 4*s + 2)) cfg_d.tog2[s][HALF_W-1:0]     = wr_data;
                if (wr_addr == ADDR_W'(ADDR_TOG_BASE + 4*s + 3)) cfg_d.tog2[s][CNT_W-1:HALF_W] = wr_data;
            end
            for (int c = 1; c < NCHG; c++) begin
                if (wr_addr == ADDR_W'(ADDR_CHG_BASE + 2*(c-1) + 0)) cfg_d.chg[c][HALF_W-1:0]     = wr_data;
                if (wr_addr == ADDR_W'(ADDR_CHG_BASE + 2*(c-1) + 1)) cfg_d.chg[c][CNT_W-1:HALF_W] = wr_data;
            end
        end
        cfg_d.chg[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= lpg_reset_cfg();
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R1: a start-level write shows up one clock later
    assert_start_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_START) |=> (cfg_q.start == $past(wr_data[NSEQ-1:0])));

endmodule

// File: rtl/lpg_seq_sel.sv
module lpg_seq_sel
    import lpg_pkg::*;
(
    input  logic [CNT_W-1:0]                line_cnt,
    input  logic [NCHG-1:0][CNT_W-1:0]      chg,
    input  logic [NCHG-1:0][SEL_W-1:0]      ptr,
    output logic [CIDX_W-1:0]               sel_idx,
    output logic [SEL_W-1:0]                sel_seq
);

    logic [CNT_W-1:0] best_line;

    always_comb begin
        sel_idx   = '0;
        best_line = chg[0];
        for (int c = 1; c < NCHG; c++) begin
            if (chg[c] <= line_cnt && chg[c] >= best_line) begin
                sel_idx   = CIDX_W'(c);
                best_line = chg[c];
            end
        end
        sel_seq = ptr[sel_idx];
    end

endmodule

// File: rtl/lpg_wave.sv
module lpg_wave
    import lpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pix_cnt,
    input  logic [SEL_W-1:0] sel_new,
    input  logic             ext_in,
    input  lpg_cfg_t         cfg,
    output logic             pulse
);

    typedef struct packed {
        logic             lvl;
        logic [SEL_W-1:0] act;
        logic [1:0]       sync;
        logic             out;
    } wave_st_t;

    wave_st_t st_d, st_q;

    logic             line_start;
    logic [SEL_W-1:0] seq;
    logic             base;
    logic             hit1, hit2;
    logic             ext_act;

    always_comb begin
        st_d       = st_q;
        line_start = (pix_cnt == '0);
        seq        = line_start ? sel_new : st_q.act;
        base       = line_start ? cfg.start[seq] : st_q.lvl;
        hit1       = (pix_cnt == cfg.tog1[seq]) && (cfg.tog1[seq] != TOG_OFF);
        hit2       = (pix_cnt == cfg.tog2[seq]) && (cfg.tog2[seq] != TOG_OFF);
        ext_act    = cfg.ext_high ? st_q.sync[1] : ~st_q.sync[1];

        st_d.act   = seq;
        st_d.lvl   = base ^ hit1 ^ hit2;
        st_d.sync  = {st_q.sync[0], ext_in};
        st_d.out   = cfg.src_ext ? ext_act : st_d.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.out;

    // R3: pixel 0 loads the start level of the selected sequence
    assert_line_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.src_ext && pix_cnt == '0 && cfg.tog1[sel_new] != '0 && cfg.tog2[sel_new] != '0)
        |=> (pulse == $past(cfg.start[sel_new])));

    // R4: away from pixel 0 and both toggles the level holds
    assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt != '0 && pix_cnt != cfg.tog1[st_q.act] && pix_cnt != cfg.tog2[st_q.act])
        |=> $stable(st_q.lvl));

    // R7: the active sequence changes only at pixel 0
    assert_seq_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt != '0) |=> $stable(st_q.act));

endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen
    import lpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  pix_cnt,
    input  logic [CNT_W-1:0]  line_cnt,
    input  logic              ext_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic              pulse_out
);

    lpg_cfg_t          cfg;
    logic [CIDX_W-1:0] sel_idx;
    logic [SEL_W-1:0]  sel_seq;

    lpg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    lpg_seq_sel u_sel (
        .line_cnt (line_cnt),
        .chg      (cfg.chg),
        .ptr      (cfg.ptr),
        .sel_idx  (sel_idx),
        .sel_seq  (sel_seq)
    );

    lpg_wave u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_cnt (pix_cnt),
        .sel_new (sel_seq),
        .ext_in  (ext_in),
        .cfg     (cfg),
        .pulse   (pulse_out)
    );

    // R6: the chosen change entry never starts after the current line
    assert_sel_not_ahead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.chg[sel_idx] <= line_cnt);

endmodule

// File: tb/sim_line_pulse_gen.sv
`timescale 1ns/1ps
module sim_line_pulse_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pix_cnt = '0;
    logic [11:0] line_cnt = '0;
    logic        ext_in = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [5:0]  wr_data = '0;
    logic        pulse_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    line_pulse_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_cnt   (pix_cnt),
        .line_cnt  (line_cnt),
        .ext_in    (ext_in),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pulse_out (pulse_out)
    );

    // {req, line, pixel, expected pulse}; default config, internal source
    localparam int NV = 19;
    localparam logic [28:0] VEC [NV] = '{
        {4'd3, 12'd2,   12'h000, 1'b1},  // R3 seq0 start
        {4'd4, 12'd2,   12'h00D, 1'b1},
        {4'd4, 12'd2,   12'h00E, 1'b0},  // R4 toggle 1
        {4'd4, 12'd2,   12'h02A, 1'b0},
        {4'd4, 12'd2,   12'h02B, 1'b1},  // R4 toggle 2
        {4'd4, 12'd2,   12'h100, 1'b1},
        {4'd2, 12'd1,   12'h000, 1'b1},  // R2 seq1 on line 1
        {4'd2, 12'd1,   12'h1AA, 1'b1},
        {4'd2, 12'd1,   12'h1AB, 1'b0},
        {4'd5, 12'd1,   12'hFFF, 1'b0},  // R5 all-ones toggle inert
        {4'd6, 12'd0,   12'h000, 1'b1},  // R6 seq3 on line 0
        {4'd6, 12'd0,   12'h00E, 1'b1},
        {4'd6, 12'd246, 12'h000, 1'b1},
        {4'd6, 12'd246, 12'h00E, 1'b0},  // R6 seq0 below line 247
        {4'd6, 12'd247, 12'h000, 1'b1},
        {4'd6, 12'd247, 12'h00E, 1'b1},  // R6 seq3 from line 247
        {4'd7, 12'd2,   12'h000, 1'b1},
        {4'd7, 12'd0,   12'h00E, 1'b0},  // R7 mid-line line change ignored
        {4'd7, 12'd0,   12'h02B, 1'b1}
    };

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pulse_out=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [5:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic [11:0] ln, input logic [11:0] px);
        line_cnt = ln; pix_cnt = px;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pulse_out, 1'b0, "R2 reset");
        rst_n = 1'b1;

        // Default: external, active low; ext_in=1 -> pulse 0
        repeat (3) @(negedge clk);
        check(pulse_out, 1'b0, "R2 default external low-active");
        ext_in = 1'b0;
        repeat (2) @(negedge clk);
        check(pulse_out, 1'b0, "R8 not before third edge");
        @(negedge clk);
        check(pulse_out, 1'b1, "R8 third edge");

        wr(5'd0, 6'd0);  // internal source (R1)
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][24:13], VEC[i][12:1]);
            checks++;
            if (pulse_out !== VEC[i][0]) begin
                errors++;
                $display("FAIL R%0d (R9 timing) row %0d: pulse_out=%0b expected=%0b",
                         VEC[i][28:25], i, pulse_out, VEC[i][0]);
            end
        end

        // R1: seq2 start 0, change entry 1 -> seq2, seq2 toggle 1 = 5
        wr(5'd1, 6'b001011);
        wr(5'd2, 6'b001011);
        wr(5'd16, 6'd5);
        wr(5'd17, 6'd0);
        step(12'd1, 12'h000); check(pulse_out, 1'b0, "R1 start level write");
        step(12'd1, 12'h005); check(pulse_out, 1'b1, "R4 seq2 toggle");
        step(12'd1, 12'h006); check(pulse_out, 1'b1, "R4 hold");

        // R4: equal toggles cancel
        wr(5'd18, 6'd5);
        wr(5'd19, 6'd0);
        step(12'd1, 12'h000); check(pulse_out, 1'b0, "R4 cancel start");
        step(12'd1, 12'h005); check(pulse_out, 1'b0, "R4 equal toggles cancel");

        // R6: change line 2 set equal to change line 1 -> entry 2 (seq0) wins
        wr(5'd26, 6'd1);
        wr(5'd27, 6'd0);
        step(12'd1, 12'h000); check(pulse_out, 1'b1, "R6 tie to higher entry");
        step(12'd1, 12'h00E); check(pulse_out, 1'b0, "R6 tie seq0 toggle");

        // R8: external, active high
        wr(5'd0, 6'd3);
        ext_in = 1'b1;
        repeat (2) @(negedge clk);
        check(pulse_out, 1'b0, "R8 high-active latency");
        @(negedge clk);
        check(pulse_out, 1'b1, "R8 high-active");
        wr(5'd0, 6'd1);
        @(negedge clk);
        check(pulse_out, 1'b0, "R8 low-active inverts");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule